// File: doc/BRIEF.md
# Alarm Clock Controller

This block is the control core of a bedside alarm clock. A free-running periodic timer pulse is divided down to one pulse per second. The seconds are counted internally and carried into a twelve-hour hours-and-minutes clock with an AM/PM flag. Only the hours and minutes leave the block, as four BCD digits and a PM lamp. A second register of the same shape holds a single alarm time. An alarm-ready flag arms that alarm, and a latched buzzer output sounds it.

The user works six already-debounced buttons. Holding the time-mode button while tapping the hour or minute button edits the running time. Holding the alarm-mode button while tapping them edits the alarm time, and the digits show the alarm for as long as that button is held. Two more buttons arm the alarm and disarm it; disarming also silences the buzzer. The alarm fires when the running time, converted to a 24-hour minute-of-day, is equal to or later than the alarm time. It only fires while the alarm is armed.

Top module: `alarm_clock_ctrl`

## Requirements
- R1: After reset the running time and the alarm time are both 12:00 AM, alarm_ready is 0, buzzer is 0, and the digits read hour tens 1, hour ones 2, minute tens 0, minute ones 0, with pm_lamp 0.
- R2: A seconds step occurs on the TICKS_PER_SEC-th cycle in which timer_tick is high, counting from the previous step. Cycles with timer_tick low do not count, however the ticks are spread out.
- R3: Seconds count 0 to 59. The step out of 59 returns them to 0 and adds one minute. Minute 59 plus one becomes minute 0 and advances the hour.
- R4: The hour advances 12, 1, 2, ..., 11, 12. Every 11-to-12 advance toggles the AM/PM flag of that register, whether it comes from a carry or a button.
- R5: With btn_set_time high and btn_set_alarm low, each 0-to-1 change of btn_hour advances the running hour once, however long it is held. Each 0-to-1 change of btn_minute advances the running minute once, wrapping 59 to 0 without touching the hour. Presses with neither mode button held change nothing.
- R6: With btn_set_alarm high, hour and minute presses edit the alarm time by the R4/R5 rules and leave the running time unchanged. The digits and pm_lamp show the alarm time while btn_set_alarm is high, and the running time otherwise.
- R7: Asserting btn_alarm_on sets alarm_ready at the next edge. Asserting btn_alarm_off clears alarm_ready and buzzer at the next edge and wins when both are high.
- R8: If alarm_ready is 1 and the running time's minute-of-day is greater than or equal to the alarm's, buzzer is 1 from the next edge on. The minute-of-day is (hour mod 12 + 12 if PM) times 60 plus minutes. Once on, buzzer stays on until btn_alarm_off.
- R9: When a seconds carry and an edit press on the running time fall in the same cycle, the carry is applied first and the press on top of its result. Both take effect.
- R10: The hour digits are 01 to 12, with the tens digit 0 or 1. The minute digits are 00 to 59. All four digits are plain BCD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_tick | input | 1 | One-cycle periodic timer pulse, divided to seconds |
| btn_set_time | input | 1 | Held: hour/minute presses edit the running time |
| btn_set_alarm | input | 1 | Held: presses edit the alarm; display shows alarm |
| btn_hour | input | 1 | Hour advance button |
| btn_minute | input | 1 | Minute advance button |
| btn_alarm_on | input | 1 | Arms the alarm |
| btn_alarm_off | input | 1 | Disarms the alarm and silences the buzzer |
| digit_hr_tens | output | 4 | BCD hour tens |
| digit_hr_ones | output | 4 | BCD hour ones |
| digit_min_tens | output | 4 | BCD minute tens |
| digit_min_ones | output | 4 | BCD minute ones |
| pm_lamp | output | 1 | PM indicator of the shown time |
| alarm_ready | output | 1 | Alarm armed |
| buzzer | output | 1 | Buzzer drive |

## Verification
The coincidence that matters is a seconds carry out of minute 59 landing in the same cycle as an hour and minute press in time-edit mode. In that cycle the hour may move twice and the minute is both carried and pressed. The bench steers its reference model to minute 59, second 59, with the divider one tick from its limit. It then raises both buttons in exactly that cycle and compares the resulting digits and PM flag against the model, which applies the carry first. Arming the alarm after its time has passed, and pressing arm and disarm together, provoke the second overlap, between the alarm comparison and the arm and disarm buttons.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int unsigned HOUR_W = 4;
  localparam int unsigned MIN_W  = 6;
  localparam int unsigned MOD_W  = 11;

  typedef struct packed {
    logic              pm;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  minute;
  } clk_time_t;

  localparam clk_time_t TIME_AT_RESET = '{pm: 1'b0, hour: 4'd12, minute: 6'd0};

  // Advance the hour of a 12-hour register; 11 -> 12 toggles AM/PM.
  function automatic clk_time_t step_hour(clk_time_t t);
    clk_time_t r;
    r = t;
    if (t.hour == 4'd11) begin
      r.hour = 4'd12;
      r.pm   = ~t.pm;
    end else if (t.hour == 4'd12) begin
      r.hour = 4'd1;
    end else begin
      r.hour = t.hour + 4'd1;
    end
    return r;
  endfunction

  // Minute advance that carries into the hour.
  function automatic clk_time_t step_minute_carry(clk_time_t t);
    clk_time_t r;
    r = t;
    if (t.minute == 6'd59) begin
      r.minute = 6'd0;
      r = step_hour(r);
    end else begin
      r.minute = t.minute + 6'd1;
    end
    return r;
  endfunction

  // Minute advance that wraps inside the hour.
  function automatic clk_time_t step_minute_wrap(clk_time_t t);
    clk_time_t r;
    r = t;
    r.minute = (t.minute == 6'd59) ? 6'd0 : t.minute + 6'd1;
    return r;
  endfunction

  // Minutes since midnight on a 24-hour scale.
  function automatic logic [MOD_W-1:0] minute_of_day(clk_time_t t);
    logic [4:0] h24;
    h24 = (t.hour == 4'd12) ? 5'd0 : {1'b0, t.hour};
    if (t.pm) h24 = h24 + 5'd12;
    return MOD_W'(h24) * MOD_W'(60) + MOD_W'(t.minute);
  endfunction

endpackage

// File: rtl/acc_reset_sync.sv
module acc_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_n_sync = shift_q[STAGES-1];

endmodule

// File: rtl/acc_mod_counter.sv
module acc_mod_counter #(
  parameter int unsigned MODULO = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic wrap
);

  localparam int unsigned CW = (MODULO > 1) ? $clog2(MODULO) : 1;
  localparam logic [CW-1:0] LAST = CW'(MODULO - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign wrap    = en && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = at_last ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/acc_time_reg.sv
module acc_time_reg
  import acc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      carry_min,
  input  logic      press_hour,
  input  logic      press_min,
  output clk_time_t time_q
);

  clk_time_t time_d;

  // Carry first, then button edits on top of the carried value.
  always_comb begin
    clk_time_t t;
    t = time_q;
    if (carry_min)  t = step_minute_carry(t);
    if (press_hour) t = step_hour(t);
    if (press_min)  t = step_minute_wrap(t);
    time_d = t;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= TIME_AT_RESET;
    else        time_q <= time_d;
  end

endmodule

// File: rtl/acc_bcd_display.sv
module acc_bcd_display
  import acc_pkg::*;
(
  input  clk_time_t   shown,
  output logic [3:0]  hr_tens,
  output logic [3:0]  hr_ones,
  output logic [3:0]  min_tens,
  output logic [3:0]  min_ones
);

  always_comb begin
    if (shown.hour >= 4'd10) begin
      hr_tens = 4'd1;
      hr_ones = shown.hour - 4'd10;
    end else begin
      hr_tens = 4'd0;
      hr_ones = shown.hour;
    end
    min_tens = 4'(shown.minute / 6'd10);
    min_ones = 4'(shown.minute % 6'd10);
  end

endmodule

// File: rtl/alarm_clock_ctrl.sv
module alarm_clock_ctrl
  import acc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 1024,
  parameter int unsigned SEC_PER_MIN   = 60,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       timer_tick,
  input  logic       btn_set_time,
  input  logic       btn_set_alarm,
  input  logic       btn_hour,
  input  logic       btn_minute,
  input  logic       btn_alarm_on,
  input  logic       btn_alarm_off,
  output logic [3:0] digit_hr_tens,
  output logic [3:0] digit_hr_ones,
  output logic [3:0] digit_min_tens,
  output logic [3:0] digit_min_ones,
  output logic       pm_lamp,
  output logic       alarm_ready,
  output logic       buzzer
);

  logic rst_core_n;
  logic sec_pulse;
  logic min_carry;

  acc_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_core_n)
  );

  acc_mod_counter #(.MODULO(TICKS_PER_SEC)) u_div (
    .clk(clk), .rst_n(rst_core_n), .en(timer_tick), .wrap(sec_pulse)
  );

  acc_mod_counter #(.MODULO(SEC_PER_MIN)) u_sec (
    .clk(clk), .rst_n(rst_core_n), .en(sec_pulse), .wrap(min_carry)
  );

  // Button edge detection against last cycle's state.
  logic hour_prev_q, min_prev_q;
  logic hour_edge, min_edge;
  logic edit_cur, edit_alm;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      hour_prev_q <= 1'b0;
      min_prev_q  <= 1'b0;
    end else begin
      hour_prev_q <= btn_hour;
      min_prev_q  <= btn_minute;
    end
  end

  assign hour_edge = btn_hour   && !hour_prev_q;
  assign min_edge  = btn_minute && !min_prev_q;
  assign edit_cur  = btn_set_time && !btn_set_alarm;
  assign edit_alm  = btn_set_alarm;

  clk_time_t cur_q, alm_q;

  acc_time_reg u_cur (
    .clk(clk), .rst_n(rst_core_n), .carry_min(min_carry),
    .press_hour(edit_cur && hour_edge), .press_min(edit_cur && min_edge),
    .time_q(cur_q)
  );

  acc_time_reg u_alm (
    .clk(clk), .rst_n(rst_core_n), .carry_min(1'b0),
    .press_hour(edit_alm && hour_edge), .press_min(edit_alm && min_edge),
    .time_q(alm_q)
  );

  // Arming and buzzer.
  logic [MOD_W-1:0] cur_mod, alm_mod;
  logic             due;
  logic             ready_q, ready_d, buzz_q, buzz_d;

  assign cur_mod = minute_of_day(cur_q);
  assign alm_mod = minute_of_day(alm_q);
  assign due     = ready_q && (cur_mod >= alm_mod);

  always_comb begin
    ready_d = ready_q;
    buzz_d  = buzz_q;
    if (btn_alarm_off) begin
      ready_d = 1'b0;
      buzz_d  = 1'b0;
    end else begin
      if (btn_alarm_on) ready_d = 1'b1;
      if (due)          buzz_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ready_q <= 1'b0;
      buzz_q  <= 1'b0;
    end else begin
      ready_q <= ready_d;
      buzz_q  <= buzz_d;
    end
  end

  assign alarm_ready = ready_q;
  assign buzzer      = buzz_q;

  // Display the register being edited.
  clk_time_t shown;
  assign shown   = btn_set_alarm ? alm_q : cur_q;
  assign pm_lamp = shown.pm;

  acc_bcd_display u_disp (
    .shown(shown), .hr_tens(digit_hr_tens), .hr_ones(digit_hr_ones),
    .min_tens(digit_min_tens), .min_ones(digit_min_ones)
  );

endmodule

// File: rtl/acc_checker.sv
module acc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       btn_alarm_on,
  input logic       btn_alarm_off,
  input logic       alarm_ready,
  input logic       buzzer,
  input logic [3:0] d_ht,
  input logic [3:0] d_ho,
  input logic [3:0] d_mt,
  input logic [3:0] d_mo
);

  // R7
  disarm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btn_alarm_off |=> (!alarm_ready && !buzzer));

  // R7
  arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_alarm_on && !btn_alarm_off) |=> alarm_ready);

  // R8
  buzzer_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buzzer && !btn_alarm_off) |=> buzzer);

  // R8
  buzzer_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buzzer) |-> $past(alarm_ready));

  // R10
  hour_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_ht <= 4'd1) && ((d_ht == 4'd1) ? (d_ho <= 4'd2) : (d_ho >= 4'd1 && d_ho <= 4'd9)));

  // R10
  minute_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_mt <= 4'd5) && (d_mo <= 4'd9));

endmodule

bind alarm_clock_ctrl acc_checker u_chk (
  .clk(clk), .rst_n(rst_core_n),
  .btn_alarm_on(btn_alarm_on), .btn_alarm_off(btn_alarm_off),
  .alarm_ready(alarm_ready), .buzzer(buzzer),
  .d_ht(digit_hr_tens), .d_ho(digit_hr_ones),
  .d_mt(digit_min_tens), .d_mo(digit_min_ones)
);

// File: tb/alarm_clock_ctrl_test.sv
module alarm_clock_ctrl_test;

  localparam int TPS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic timer_tick = 1'b0;
  logic b_st = 1'b0, b_sa = 1'b0, b_hr = 1'b0, b_mn = 1'b0, b_on = 1'b0, b_off = 1'b0;
  logic [3:0] d_ht, d_ho, d_mt, d_mo;
  logic pm_lamp, alarm_ready, buzzer;

  always #5 clk = ~clk;

  alarm_clock_ctrl #(.TICKS_PER_SEC(TPS)) uut (
    .clk(clk), .rst_n(rst_n), .timer_tick(timer_tick),
    .btn_set_time(b_st), .btn_set_alarm(b_sa), .btn_hour(b_hr), .btn_minute(b_mn),
    .btn_alarm_on(b_on), .btn_alarm_off(b_off),
    .digit_hr_tens(d_ht), .digit_hr_ones(d_ho), .digit_min_tens(d_mt), .digit_min_ones(d_mo),
    .pm_lamp(pm_lamp), .alarm_ready(alarm_ready), .buzzer(buzzer)
  );

  // Behavioural reference state.
  int m_div, m_sec, m_h, m_m, m_pm, a_h, a_m, a_pm, m_ready, m_buzz, p_hr, p_mn;
  int vectors = 0, misses = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  function automatic int tod(int h, int m, int pm);
    return ((h % 12) + (pm ? 12 : 0)) * 60 + m;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_sec = 0; m_h = 12; m_m = 0; m_pm = 0;
      a_h = 12; a_m = 0; a_pm = 0; m_ready = 0; m_buzz = 0; p_hr = 0; p_mn = 0;
    end else begin
      int nr, nb;
      bit carry, he, me;
      nr = m_ready; nb = m_buzz;
      if (b_off) begin nr = 0; nb = 0; end
      else begin
        if (b_on) nr = 1;
        if (m_ready != 0 && tod(m_h, m_m, m_pm) >= tod(a_h, a_m, a_pm)) nb = 1;
      end
      carry = 0;
      if (timer_tick) begin
        m_div++;
        if (m_div == TPS) begin
          m_div = 0; m_sec++;
          if (m_sec == 60) begin m_sec = 0; carry = 1; end
        end
      end
      he = b_hr && !p_hr;
      me = b_mn && !p_mn;
      if (carry) begin
        m_m++;
        if (m_m == 60) begin
          m_m = 0;
          if (m_h == 11) m_pm = !m_pm;
          m_h = (m_h == 12) ? 1 : m_h + 1;
        end
      end
      if (b_st && !b_sa) begin
        if (he) begin if (m_h == 11) m_pm = !m_pm; m_h = (m_h == 12) ? 1 : m_h + 1; end
        if (me) m_m = (m_m + 1) % 60;
      end
      if (b_sa) begin
        if (he) begin if (a_h == 11) a_pm = !a_pm; a_h = (a_h == 12) ? 1 : a_h + 1; end
        if (me) a_m = (a_m + 1) % 60;
      end
      m_ready = nr; m_buzz = nb;
      p_hr = b_hr; p_mn = b_mn;
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  // Compare every cycle, away from the rising edge.
  always @(negedge clk) begin
    int sh, sm, sp;
    cycles++;
    if (cycles > 150000) begin
      misses++;
      $display("FAIL watchdog %s: actual running, expected finished", cur_req);
      summary();
    end
    sh = b_sa ? a_h : m_h; sm = b_sa ? a_m : m_m; sp = b_sa ? a_pm : m_pm;
    vectors++;
    if (d_ht != sh / 10 || d_ho != sh % 10 || d_mt != sm / 10 || d_mo != sm % 10 ||
        pm_lamp != sp[0] || alarm_ready != m_ready[0] || buzzer != m_buzz[0]) begin
      misses++;
      $display("FAIL %s: actual %0d%0d:%0d%0d pm=%0d rdy=%0d bz=%0d expected %02d:%02d pm=%0d rdy=%0d bz=%0d",
               cur_req, d_ht, d_ho, d_mt, d_mo, pm_lamp, alarm_ready, buzzer,
               sh, sm, sp, m_ready, m_buzz);
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic press_hour();
    b_hr = 1; idle(4); b_hr = 0; idle(1);
  endtask

  task automatic press_min();
    b_mn = 1; idle(3); b_mn = 0; idle(1);
  endtask

  initial begin
    logic [7:0] lfsr;
    // R1: reset state
    cur_req = "R1";
    idle(3); rst_n = 1; idle(5);

    // R3: free running with a tick every cycle
    cur_req = "R3"; timer_tick = 1; idle(400);

    // R2: irregular tick pattern through the divider
    cur_req = "R2"; lfsr = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      timer_tick = lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      idle(1);
    end
    timer_tick = 1;

    // R5: presses without a mode button are ignored; held press counts once
    cur_req = "R5"; press_hour(); press_min();
    b_st = 1; press_hour(); press_min(); press_min();

    // R4: walk the hour through a full cycle and into 11 PM
    cur_req = "R4";
    for (int i = 0; i < 12; i++) press_hour();
    while (!(m_h == 11 && m_pm == 1)) press_hour();
    while (m_m != 58) press_min();
    b_st = 0;

    // R3: midnight rollover 11:59 PM -> 12:00 AM
    cur_req = "R3"; idle(300);

    // R9: carry and presses in the same cycle
    cur_req = "R9"; b_st = 1;
    while (m_m != 59) press_min();
    while (!(m_sec == 59 && m_div == TPS - 1)) idle(1);
    b_hr = 1; b_mn = 1; idle(1); b_hr = 0; b_mn = 0; idle(3);
    b_st = 0; idle(2);

    // R6: edit the alarm to two minutes ahead; running time untouched
    cur_req = "R6"; b_sa = 1;
    while (!(a_h == m_h && a_pm == m_pm)) press_hour();
    while (a_m != (m_m + 2) % 60) press_min();
    b_st = 1; press_hour(); b_st = 0;
    while (!(a_h == m_h && a_pm == m_pm)) press_hour();
    b_sa = 0; idle(2);

    // R7: arm
    cur_req = "R7"; b_on = 1; idle(1); b_on = 0; idle(2);
    // R8: wait for the buzzer and its latch
    cur_req = "R8"; idle(400);
    // R7: disarm silences
    cur_req = "R7"; b_off = 1; idle(1); b_off = 0; idle(3);
    // R8: arming past the alarm time fires at once
    cur_req = "R8"; b_on = 1; idle(1); b_on = 0; idle(5);
    // R7: both buttons, disarm wins
    cur_req = "R7"; b_on = 1; b_off = 1; idle(1); b_on = 0; b_off = 0; idle(3);

    // R10: digit encoding over a longer run
    cur_req = "R10"; idle(1500);

    summary();
  end

endmodule